// File: doc/BRIEF.md
# Maskable Interrupt Controller with Software Posting

This block gathers interrupt requests from up to `NUM_GROUPS * REG_W` hardware sources (24 by default) and turns them into one interrupt request line plus a vector index. Each source owns a posted latch. The latch sets on a rising edge of that source's request input, and it stays set until software clears it. Each source also has a mask bit. A posted source becomes pending only while its mask bit is 1. A fixed-priority encoder picks the lowest-numbered pending source.

Software reaches the block through a synchronous byte-wide register port. The posted bits are readable as one status register per group of `REG_W` sources. Writes to a status register are read in one of two ways, chosen by a software-post enable bit held in the top bit of a control register. With the enable at 0, a written 0 clears the posted bit and a written 1 does nothing. With the enable at 1, a written 1 posts the interrupt and a written 0 does nothing. The second way lets software raise any interrupt without its hardware, for example to exercise a service routine.

With the default address parameters, the status registers for groups 0..2 sit at 0x20..0x22. The mask registers for groups 0..2 sit at 0x24..0x26. The control register is at 0x27: its bit 7 is the software-post enable, and its bits 6..0 are reserved. Status group g holds sources g*8 .. g*8+7, with bit b mapping to source g*8+b.

Top module: `irq_post_ctrl`

## Requirements
- R1: After reset, every posted bit, every mask bit and the software-post enable are 0, `irq` is 0, and every register reads back 0.
- R2: A 0-to-1 change of `hw_req[i]` sets posted bit i on the next clock edge. A request that stays high does not post again once its bit has been cleared. A request that is high when reset is released counts as a rising edge.
- R3: Reads are synchronous. When `bus_rd` is 1 at a clock edge, `bus_rdata` takes the value of the addressed register at that edge and holds it until the next read. Status registers return the posted bits, and mask registers return the mask bits. The control register returns the enable in bit 7 and 0 in bits 6..0. Its reserved bits ignore writes. Unmapped addresses (for example 0x23 or 0x10) read 0.
- R4: With the software-post enable at 0, writing 0 to a status-register bit clears that posted bit, and writing 1 leaves it unchanged.
- R5: With the software-post enable at 1, writing 1 to a status-register bit sets that posted bit, and writing 0 leaves it unchanged.
- R6: A source is pending when its posted bit and its mask bit are both 1. A mask bit of 0 keeps the source off `irq` but does not stop it from posting. Each mask bit affects only its own source.
- R7: `irq` is 1 exactly when at least one source is pending. `irq_vec` then gives the lowest pending source index, and it is 0 while `irq` is 0. Both follow the registered state within the same cycle.
- R8: If a hardware rising edge and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: A write to the control register updates the software-post enable from data bit 7 at that clock edge. A status write in the same cycle is still read using the old enable value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_GROUPS*REG_W | Hardware request per source, posted on rising edge |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | REG_W | Write data |
| bus_rd | input | 1 | Read strobe, result on `bus_rdata` after the edge |
| bus_rdata | output | REG_W | Registered read data |
| irq | output | 1 | Any source pending |
| irq_vec | output | $clog2(NUM_GROUPS*REG_W) | Lowest pending source index |

## Verification
Two functions can act on the same posted bit in the same cycle: a hardware rising edge, and a status-register write that would clear it. The bench provokes this with a directed cycle in which a request rises while a zero is written to its bit. It then reads the register and expects the bit to be set. Constrained-random traffic repeats the overlap many times, combining sparse request toggles with random writes to all mapped registers and flips of the enable bit. A bench model that applies the post-wins rule judges `irq`, `irq_vec` and every read on every cycle.

// File: rtl/irq_post_ctrl_pkg.sv
package irq_post_ctrl_pkg;

   // Kind of register the current bus address selects.
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_STAT = 2'd1,
      ACC_MASK = 2'd2,
      ACC_CTRL = 2'd3
   } acc_kind_e;

   function automatic int grp_width(input int groups);
      return (groups > 1) ? $clog2(groups) : 1;
   endfunction

endpackage

// File: rtl/irq_post_bank.sv
module irq_post_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   input  logic         wr_hit,
   input  logic         sw_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] posted
);

   logic [W-1:0] req_q;
   logic [W-1:0] rise;
   logic [W-1:0] sw_set;
   logic [W-1:0] sw_clr;

   assign rise   = req & ~req_q;
   assign sw_set = {W{wr_hit &  sw_en}} &  wdata;
   assign sw_clr = {W{wr_hit & ~sw_en}} & ~wdata;

   // A set, from hardware or software, takes precedence over a clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         posted <= '0;
      end else begin
         req_q  <= req;
         posted <= (posted & ~sw_clr) | rise | sw_set;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_chk
      assert_hw_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> posted[i]);
      assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && !sw_en && !wdata[i] && !rise[i]) |=> !posted[i]);
      assert_one_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && !sw_en && wdata[i] && !rise[i]) |=> $stable(posted[i]));
      assert_sw_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && sw_en && wdata[i]) |=> posted[i]);
      assert_zero_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && sw_en && !wdata[i] && !rise[i]) |=> $stable(posted[i]));
      assert_post_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (rise[i] && wr_hit && !sw_en && !wdata[i]) |=> posted[i]);
      assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!rise[i] && !wr_hit) |=> $stable(posted[i]));
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N     = 24,
   parameter int VEC_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pending,
   output logic             irq,
   output logic [VEC_W-1:0] vec
);

   assign irq = |pending;

   // Scan from the top down so that the lowest index is written last and wins.
   always_comb begin
      vec = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pending[i]) vec = VEC_W'(i);
      end
   end

   assert_vec_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pending[vec]);
   assert_vec_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((pending & ((N'(1) << vec) - N'(1))) == '0));
   assert_idle_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (pending == '0 && vec == '0));

endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
   import irq_post_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_GROUPS = 3,
   parameter int REG_W      = 8,
   parameter int STAT_BASE  = 'h20,
   parameter int MASK_BASE  = 'h24,
   localparam int NUM_SRC   = NUM_GROUPS * REG_W,
   localparam int GRP_W     = grp_width(NUM_GROUPS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [REG_W-1:0]      bus_wdata,
   input  logic                  bus_rd,
   input  logic [NUM_SRC-1:0]    posted,
   output logic [REG_W-1:0]      bus_rdata,
   output logic [NUM_SRC-1:0]    mask,
   output logic                  sw_en,
   output logic [NUM_GROUPS-1:0] stat_wr
);

   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(MASK_BASE + NUM_GROUPS);

   acc_kind_e        acc;
   logic [GRP_W-1:0] grp;
   logic [REG_W-1:0] rd_next;

   always_comb begin
      acc = ACC_NONE;
      grp = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (bus_addr == ADDR_W'(STAT_BASE + g)) begin
            acc = ACC_STAT;
            grp = GRP_W'(g);
         end
         if (bus_addr == ADDR_W'(MASK_BASE + g)) begin
            acc = ACC_MASK;
            grp = GRP_W'(g);
         end
      end
      if (bus_addr == CTRL_ADDR) acc = ACC_CTRL;
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign stat_wr[g] = bus_wr && (acc == ACC_STAT) && (grp == GRP_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask[g*REG_W +: REG_W] <= '0;
         else if (bus_wr && (acc == ACC_MASK) && (grp == GRP_W'(g)))
            mask[g*REG_W +: REG_W] <= bus_wdata;
      end
   end

   // The control register stores only its top bit; the rest are reserved.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sw_en <= 1'b0;
      else if (bus_wr && (acc == ACC_CTRL))
         sw_en <= bus_wdata[REG_W-1];
   end

   always_comb begin
      unique case (acc)
         ACC_STAT: rd_next = posted[int'(grp)*REG_W +: REG_W];
         ACC_MASK: rd_next = mask[int'(grp)*REG_W +: REG_W];
         ACC_CTRL: rd_next = {sw_en, (REG_W-1)'(0)};
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_next;
   end

   assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_ADDR) |=> (sw_en == $past(bus_wdata[REG_W-1])));
   assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == CTRL_ADDR) |=> $stable(sw_en));
   assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   assert_stat_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stat_wr) && (stat_wr == '0 || bus_wr));

endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl #(
   parameter int ADDR_W     = 8,
   parameter int NUM_GROUPS = 3,
   parameter int REG_W      = 8,
   parameter int STAT_BASE  = 'h20,
   parameter int MASK_BASE  = 'h24,
   localparam int NUM_SRC   = NUM_GROUPS * REG_W,
   localparam int VEC_W     = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_req,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   input  logic               bus_rd,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               irq,
   output logic [VEC_W-1:0]   irq_vec
);

   if (NUM_GROUPS < 1 || REG_W < 2) begin : g_bad_shape
      $error("irq_post_ctrl: need at least one group of two or more bits");
   end
   if ((STAT_BASE + NUM_GROUPS > MASK_BASE) && (MASK_BASE + NUM_GROUPS + 1 > STAT_BASE)) begin : g_bad_map
      $error("irq_post_ctrl: status and mask address windows overlap");
   end
   if (STAT_BASE + NUM_GROUPS > (1 << ADDR_W) || MASK_BASE + NUM_GROUPS + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_post_ctrl: register window exceeds address space");
   end

   logic [NUM_SRC-1:0]    posted;
   logic [NUM_SRC-1:0]    mask;
   logic [NUM_SRC-1:0]    pending;
   logic                  sw_en;
   logic [NUM_GROUPS-1:0] stat_wr;

   irq_bus_regs #(
      .ADDR_W     (ADDR_W),
      .NUM_GROUPS (NUM_GROUPS),
      .REG_W      (REG_W),
      .STAT_BASE  (STAT_BASE),
      .MASK_BASE  (MASK_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .posted    (posted),
      .bus_rdata (bus_rdata),
      .mask      (mask),
      .sw_en     (sw_en),
      .stat_wr   (stat_wr)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
      irq_post_bank #(.W(REG_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .req    (hw_req[g*REG_W +: REG_W]),
         .wr_hit (stat_wr[g]),
         .sw_en  (sw_en),
         .wdata  (bus_wdata),
         .posted (posted[g*REG_W +: REG_W])
      );
   end

   assign pending = posted & mask;

   irq_prio_enc #(.N(NUM_SRC), .VEC_W(VEC_W)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (pending),
      .irq     (irq),
      .vec     (irq_vec)
   );

   assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask[irq_vec] && posted[irq_vec]));
   assert_no_irq_unposted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (posted == '0) |-> !irq);

endmodule

// File: tb/irq_post_ctrl_bench.sv
`timescale 1ns/1ps
module irq_post_ctrl_bench;

   localparam int NS = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] hw_req = '0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_rdata;
   logic          irq;
   logic [4:0]    irq_vec;

   irq_post_ctrl u_irq_post_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_req    (hw_req),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq       (irq),
      .irq_vec   (irq_vec)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [NS-1:0] m_post = '0, m_mask = '0, m_req = '0, cur_req = '0;
   bit            m_sw = 1'b0;
   logic [7:0]    last_rd;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [7:0] a);
      if (a >= 8'h20 && a <= 8'h22) return m_post[(a - 8'h20) * 8 +: 8];
      if (a >= 8'h24 && a <= 8'h26) return m_mask[(a - 8'h24) * 8 +: 8];
      if (a == 8'h27) return {m_sw, 7'b0};
      return 8'h00;
   endfunction

   function automatic int lowest(input logic [NS-1:0] p);
      for (int i = 0; i < NS; i++) if (p[i]) return i;
      return 0;
   endfunction

   task automatic cyc(input logic [NS-1:0] rq, input bit wr, input logic [7:0] a,
                      input logic [7:0] d, input bit rd);
      logic [7:0]    exp_rd;
      logic [NS-1:0] rise;
      @(negedge clk);
      hw_req = rq; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_rd = rd;
      exp_rd = model_read(a);
      @(posedge clk);
      rise  = rq & ~m_req;
      m_req = rq;
      if (wr) begin
         if (a >= 8'h20 && a <= 8'h22) begin
            for (int b = 0; b < 8; b++) begin
               if (m_sw && d[b])       m_post[(a - 8'h20) * 8 + b] = 1'b1;
               else if (!m_sw && !d[b]) m_post[(a - 8'h20) * 8 + b] = 1'b0;
            end
         end else if (a >= 8'h24 && a <= 8'h26) begin
            m_mask[(a - 8'h24) * 8 +: 8] = d;
         end else if (a == 8'h27) begin
            m_sw = d[7];
         end
      end
      m_post = m_post | rise;
      #1;
      chk("R7 irq", int'(irq), int'(|(m_post & m_mask)));
      chk("R7 irq_vec", int'(irq_vec), lowest(m_post & m_mask));
      if (rd) begin
         last_rd = bus_rdata;
         chk("R3 read", int'(bus_rdata), int'(exp_rd));
      end
   endtask

   task automatic idle();
      cyc(cur_req, 1'b0, 8'h00, 8'h00, 1'b0);
   endtask
   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      cyc(cur_req, 1'b1, a, d, 1'b0);
   endtask
   task automatic rd_reg(input logic [7:0] a);
      cyc(cur_req, 1'b0, a, 8'h00, 1'b1);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle();
      chk("R1 irq after reset", int'(irq), 0);
      for (int a = 8'h20; a <= 8'h27; a++) begin
         rd_reg(8'(a));
         chk("R1 register clear", int'(last_rd), 0);
      end

      // R2, R6: rising edge posts while masked
      cur_req = 24'h000020;
      idle();
      rd_reg(8'h20);
      chk("R2 edge posted", int'(last_rd), 8'h20);
      chk("R6 masked no irq", int'(irq), 0);

      // R7: unmask
      wr_reg(8'h24, 8'h20);
      chk("R7 irq raised", int'(irq), 1);
      chk("R7 vector 5", int'(irq_vec), 5);

      // R4: ones ignored, zero clears
      wr_reg(8'h20, 8'hFF);
      rd_reg(8'h20);
      chk("R4 one ignored", int'(last_rd), 8'h20);
      wr_reg(8'h20, 8'hDF);
      rd_reg(8'h20);
      chk("R4 zero clears", int'(last_rd), 8'h00);

      // R2: level held high does not re-post
      idle(); idle();
      rd_reg(8'h20);
      chk("R2 no repost on level", int'(last_rd), 8'h00);

      // R9, R3: enable bit, reserved bits read 0
      wr_reg(8'h27, 8'hFF);
      rd_reg(8'h27);
      chk("R9 enable set, R3 reserved zero", int'(last_rd), 8'h80);

      // R5: software post, zeros ignored
      wr_reg(8'h21, 8'h01);
      rd_reg(8'h21);
      chk("R5 software post", int'(last_rd), 8'h01);
      wr_reg(8'h21, 8'h00);
      rd_reg(8'h21);
      chk("R5 zero ignored", int'(last_rd), 8'h01);
      wr_reg(8'h27, 8'h00);

      // R8: edge and clear in the same cycle
      cur_req = '0;
      idle();
      cur_req = 24'h000008;
      cyc(cur_req, 1'b1, 8'h20, 8'h00, 1'b0);
      rd_reg(8'h20);
      chk("R8 post wins over clear", int'(last_rd), 8'h08);

      // R7: priority between bit 3 and bit 8
      wr_reg(8'h24, 8'hFF);
      wr_reg(8'h25, 8'hFF);
      chk("R7 lowest is 3", int'(irq_vec), 3);
      wr_reg(8'h20, 8'hF7);
      chk("R7 next is 8", int'(irq_vec), 8);

      // R6: mask only gates, posting kept
      wr_reg(8'h25, 8'hFE);
      chk("R6 bit 8 masked", int'(irq), 0);
      rd_reg(8'h21);
      chk("R6 still posted", int'(last_rd), 8'h01);
      rd_reg(8'h25);
      chk("R6 other mask bits kept", int'(last_rd), 8'hFE);

      // R3: unmapped reads
      rd_reg(8'h23);
      chk("R3 unmapped 0x23", int'(last_rd), 0);
      rd_reg(8'h10);
      chk("R3 unmapped 0x10", int'(last_rd), 0);

      // Constrained random traffic, overlapping edges and writes
      for (int n = 0; n < 3000; n++) begin
         logic [NS-1:0] flip;
         int op;
         flip    = NS'($urandom & $urandom & $urandom);
         cur_req = cur_req ^ flip;
         op      = int'($urandom % 4);
         cyc(cur_req, op != 0, 8'h20 + 8'($urandom % 8), 8'($urandom), ($urandom % 2) == 1);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule